// File: doc/BRIEF.md
# Transmit Permission and Timeout Controller

This block is the keying arbiter of a packet data radio. It decides, cycle by cycle, whether the transmitter may be switched on. It also schedules how the receiver is powered when the radio is idle. A host keeps `tx_req` high for as long as it wants to send. The arbiter grants the request unless busy-channel lockout is enabled and the carrier-detect flag shows that the channel is occupied when the request starts. While transmitting, an optional timer limits how long one unbroken transmission may last. The limit is programmed as a step count, and each step is ten seconds of 1 ms ticks.

When the radio is idle and power saving is enabled, the receiver supply is switched between a programmable awake time and a programmable sleep time, both counted in 1 ms ticks. Any transmit request or detected carrier stops this cycling and keeps the receiver powered. Every pin is a plain control or status level. No data passes through the block, so there is no valid/ready handshake and no back-pressure. The step length is a parameter, so that a bench can shorten it.

Top module: `tpc_keying_arbiter`

## Requirements
- R1: While `rst_n` is low, `tx_en` is 0, `tot_expired` is 0 and `rx_pwr_en` is 1.
- R2: From idle, a request on a free channel makes `tx_en` high one clock later. Dropping the request makes `tx_en` low one clock later.
- R3: If `cfg_lockout_en` is 1 and `chan_busy` is 1 when a request starts, `tx_en` stays low for as long as that request is held, even if the channel clears. A request made after release and re-assertion on a free channel is granted.
- R4: With `cfg_lockout_en` at 0, `chan_busy` has no effect on granting.
- R5: A channel that becomes busy during an active transmission does not end that transmission.
- R6: With the timeout enabled and setting code N (1 to 99), `tx_en` stays high for exactly N×TICKS_PER_STEP ticks, and then drops.
- R7: Setting code 0 acts as 1, and codes above 99 act as 99.
- R8: After a timeout, `tx_en` stays low and `tot_expired` stays high until the request is released. One clock after release the flag clears, and a new request gets the full duration again.
- R9: With the timeout disabled, a held request keeps `tx_en` high with no limit.
- R10: With `cfg_ps_en` at 0, `rx_pwr_en` stays at 1. With it at 1 and the radio idle, `rx_pwr_en` alternates: high for `cfg_rx_on_ms` ticks and low for `cfg_rx_off_ms` ticks (a value of 0 acts as 1).
- R11: A transmit request or a busy channel forces `rx_pwr_en` to 1 one clock later, and keeps it there.
- R12: Timeout settings changed during a transmission take effect only at the next idle. The running transmission keeps the limit it started with.
- R13: `tx_en` and `tot_expired` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| tx_req | input | 1 | Host asks to transmit (level) |
| chan_busy | input | 1 | Carrier detected on the receive channel |
| cfg_lockout_en | input | 1 | Enable busy-channel lockout |
| cfg_tot_en | input | 1 | Enable the transmit time limit |
| cfg_tot_code | input | 7 | Time limit in ten-second steps |
| cfg_ps_en | input | 1 | Enable receiver power-save cycling |
| cfg_rx_on_ms | input | 16 | Receiver awake time in ticks |
| cfg_rx_off_ms | input | 16 | Receiver sleep time in ticks |
| tx_en | output | 1 | Transmitter keyed |
| rx_pwr_en | output | 1 | Receiver supply on |
| tot_expired | output | 1 | Transmission cut off by the timer |

## Verification
The two counters are the main risk. A step counter that is off by one, or that is not cleared on entry, shows up as the measured length of a granted transmission, which differs from N×step at the first expiry. A key state stuck in the busy hold or the timeout hold shows up as `tx_en` staying low one clock after a legal request. A sleep scheduler with a wrong phase or count shows up as the wrong length of the first high or low run of `rx_pwr_en`, within one on-plus-off period.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  typedef enum logic [1:0] {
    KEY_IDLE      = 2'd0,
    KEY_ON        = 2'd1,
    KEY_BLOCKED   = 2'd2,
    KEY_TIMED_OUT = 2'd3
  } key_state_e;
endpackage

// File: rtl/tpc_step_timer.sv
// Continuous-transmit timer: a tick prescaler feeding a step counter.
module tpc_step_timer #(
  parameter int unsigned TICKS_PER_STEP = 10000,
  parameter int unsigned CODE_W         = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic              limit_en,
  input  logic [CODE_W-1:0] limit_steps,
  output logic              done
);
  localparam int unsigned SUB_W = (TICKS_PER_STEP > 1) ? $clog2(TICKS_PER_STEP) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_STEP - 1);

  logic [SUB_W-1:0]  sub_q;
  logic [CODE_W-1:0] step_q;
  logic              step_wrap;

  assign step_wrap = tick && (sub_q == SUB_LAST);
  assign done = run && limit_en && step_wrap &&
                ((step_q + CODE_W'(1)) == limit_steps);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      sub_q  <= '0;
      step_q <= '0;
    end else if (tick) begin
      if (step_wrap) begin
        sub_q <= '0;
        if (limit_en && (step_q != '1)) step_q <= step_q + CODE_W'(1);
      end else begin
        sub_q <= sub_q + SUB_W'(1);
      end
    end
  end
endmodule

// File: rtl/tpc_key_fsm.sv
// Keying state machine: lockout at request start, timeout hold, release.
module tpc_key_fsm
  import tpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_req,
  input  logic       chan_busy,
  input  logic       lock_en,
  input  logic       tout_done,
  output key_state_e state
);
  key_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      KEY_IDLE:
        if (tx_req) state_d = (lock_en && chan_busy) ? KEY_BLOCKED : KEY_ON;
      KEY_ON:
        if (!tx_req)        state_d = KEY_IDLE;
        else if (tout_done) state_d = KEY_TIMED_OUT;
      KEY_BLOCKED, KEY_TIMED_OUT:
        if (!tx_req) state_d = KEY_IDLE;
      default: state_d = KEY_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= KEY_IDLE;
    else        state <= state_d;
  end
endmodule

// File: rtl/tpc_rx_sched.sv
// Receiver sleep/wake duty-cycle scheduler.
module tpc_rx_sched #(
  parameter int unsigned PS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            tick,
  input  logic [PS_W-1:0] on_ticks,
  input  logic [PS_W-1:0] off_ticks,
  output logic            rx_on
);
  logic            asleep_q;
  logic [PS_W-1:0] cnt_q;
  logic [PS_W-1:0] lim_sel;
  logic [PS_W-1:0] lim_eff;
  logic [PS_W:0]   cnt_nxt;

  always_comb begin
    lim_sel = asleep_q ? off_ticks : on_ticks;
    lim_eff = (lim_sel == '0) ? PS_W'(1) : lim_sel;
    cnt_nxt = {1'b0, cnt_q} + (PS_W+1)'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      asleep_q <= 1'b0;
      cnt_q    <= '0;
    end else if (tick) begin
      if (cnt_nxt >= {1'b0, lim_eff}) begin
        asleep_q <= !asleep_q;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_nxt[PS_W-1:0];
      end
    end
  end

  assign rx_on = !asleep_q;
endmodule

// File: rtl/tpc_keying_arbiter.sv
// Top: keying arbiter with timeout and receiver power-save scheduling.
module tpc_keying_arbiter
  import tpc_pkg::*;
#(
  parameter int unsigned TICKS_PER_STEP = 10000,
  parameter int unsigned CODE_W         = 7,
  parameter int unsigned TOUT_MAX_CODE  = 99,
  parameter int unsigned PS_W           = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_ms,
  input  logic              tx_req,
  input  logic              chan_busy,
  input  logic              cfg_lockout_en,
  input  logic              cfg_tot_en,
  input  logic [CODE_W-1:0] cfg_tot_code,
  input  logic              cfg_ps_en,
  input  logic [PS_W-1:0]   cfg_rx_on_ms,
  input  logic [PS_W-1:0]   cfg_rx_off_ms,
  output logic              tx_en,
  output logic              rx_pwr_en,
  output logic              tot_expired
);
  localparam logic [CODE_W-1:0] CODE_TOP = CODE_W'(TOUT_MAX_CODE);

  key_state_e        key_state;
  logic              tout_done;
  logic [CODE_W-1:0] code_eff;
  logic [CODE_W-1:0] code_q;
  logic              tot_en_q;
  logic              ps_active;

  // Clamp the step code: 0 means one step, values above the top are limited.
  always_comb begin
    if (cfg_tot_code == '0)          code_eff = CODE_W'(1);
    else if (cfg_tot_code > CODE_TOP) code_eff = CODE_TOP;
    else                              code_eff = cfg_tot_code;
  end

  // Timeout settings are taken only while idle and frozen during a transmission.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q   <= CODE_W'(1);
      tot_en_q <= 1'b0;
    end else if (key_state == KEY_IDLE) begin
      code_q   <= code_eff;
      tot_en_q <= cfg_tot_en;
    end
  end

  tpc_key_fsm i_key_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_req    (tx_req),
    .chan_busy (chan_busy),
    .lock_en   (cfg_lockout_en),
    .tout_done (tout_done),
    .state     (key_state)
  );

  tpc_step_timer #(
    .TICKS_PER_STEP (TICKS_PER_STEP),
    .CODE_W         (CODE_W)
  ) i_step_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (key_state == KEY_ON),
    .tick        (tick_ms),
    .limit_en    (tot_en_q),
    .limit_steps (code_q),
    .done        (tout_done)
  );

  assign ps_active = cfg_ps_en && (key_state == KEY_IDLE) && !tx_req && !chan_busy;

  tpc_rx_sched #(
    .PS_W (PS_W)
  ) i_rx_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (ps_active),
    .tick      (tick_ms),
    .on_ticks  (cfg_rx_on_ms),
    .off_ticks (cfg_rx_off_ms),
    .rx_on     (rx_pwr_en)
  );

  assign tx_en       = (key_state == KEY_ON);
  assign tot_expired = (key_state == KEY_TIMED_OUT);
endmodule

// File: rtl/tpc_keying_arbiter_chk.sv
module tpc_keying_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_req,
  input logic chan_busy,
  input logic cfg_lockout_en,
  input logic cfg_ps_en,
  input logic tx_en,
  input logic rx_pwr_en,
  input logic tot_expired
);
  AST_RELEASE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_req |=> (!tx_en && !tot_expired)); // R2
  AST_LOCKOUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && tx_req && cfg_lockout_en && chan_busy) |=> !tx_en); // R3
  AST_BUSY_NO_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && tx_req) |=> (tx_en || tot_expired)); // R5
  AST_EXPIRED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tot_expired && tx_req) |=> (tot_expired && !tx_en)); // R8
  AST_PS_OFF_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ps_en |=> rx_pwr_en); // R10
  AST_SUSPEND_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req || chan_busy) |=> rx_pwr_en); // R11
  AST_KEY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_en && tot_expired)); // R13
endmodule

bind tpc_keying_arbiter tpc_keying_arbiter_chk i_chk (.*);

// File: tb/test_tpc_keying_arbiter.sv
module test_tpc_keying_arbiter;
  localparam int unsigned TPS = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_ms = 1'b1;
  logic        tx_req = 1'b0;
  logic        chan_busy = 1'b0;
  logic        cfg_lockout_en = 1'b0;
  logic        cfg_tot_en = 1'b0;
  logic [6:0]  cfg_tot_code = 7'd1;
  logic        cfg_ps_en = 1'b0;
  logic [15:0] cfg_rx_on_ms = 16'd3;
  logic [15:0] cfg_rx_off_ms = 16'd2;
  logic        tx_en, rx_pwr_en, tot_expired;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  typedef struct { string tag; int val; } exp_t;
  exp_t exp_q[$];
  int   act_q[$];

  always #10 clk = !clk;

  tpc_keying_arbiter #(.TICKS_PER_STEP(TPS)) i_tpc_keying_arbiter (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .tx_req(tx_req),
    .chan_busy(chan_busy), .cfg_lockout_en(cfg_lockout_en),
    .cfg_tot_en(cfg_tot_en), .cfg_tot_code(cfg_tot_code),
    .cfg_ps_en(cfg_ps_en), .cfg_rx_on_ms(cfg_rx_on_ms),
    .cfg_rx_off_ms(cfg_rx_off_ms), .tx_en(tx_en),
    .rx_pwr_en(rx_pwr_en), .tot_expired(tot_expired)
  );

  // Driver side: queue the expected item together with the observation.
  task automatic expect_item(string tag, int act, int exp_val);
    exp_t e;
    e.tag = tag;
    e.val = exp_val;
    exp_q.push_back(e);
    act_q.push_back(act);
  endtask

  // Monitor: pops and compares queued items.
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0 && act_q.size() > 0) begin
        exp_t e;
        int a;
        e = exp_q.pop_front();
        a = act_q.pop_front();
        checks++;
        if (a != e.val) begin
          errors++;
          $display("FAIL %s actual=%0d expected=%0d", e.tag, a, e.val);
        end
      end
    end
  end

  task automatic run_tx(input int cap, output int n);
    n = 0;
    tx_req = 1'b1;
    for (int i = 0; i < cap; i++) begin
      @(negedge clk);
      if (tx_en) n++;
      else break;
    end
  endtask

  task automatic release_req();
    tx_req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    expect_item("R1 tx_en in reset", int'(tx_en), 0);
    expect_item("R1 rx_pwr_en in reset", int'(rx_pwr_en), 1);
    expect_item("R1 tot_expired in reset", int'(tot_expired), 0);
    rst_n = 1'b1;
    cfg_lockout_en = 1'b1;
    cfg_tot_en = 1'b1;
    cfg_tot_code = 7'd3;
    @(negedge clk);

    // R2 grant and release latency
    tx_req = 1'b1;
    @(negedge clk);
    expect_item("R2 grant after one clock", int'(tx_en), 1);
    tx_req = 1'b0;
    @(negedge clk);
    expect_item("R2 drop after one clock", int'(tx_en), 0);

    // R6 timeout length, R8 hold and restart, R13 exclusivity
    run_tx(1000, n);
    expect_item("R6 duration code 3", n, 3 * TPS);
    expect_item("R8 flag after expiry", int'(tot_expired), 1);
    repeat (4) @(negedge clk);
    expect_item("R8 tx stays off while held", int'(tx_en), 0);
    expect_item("R13 flag still high, tx low", int'(tot_expired && !tx_en), 1);
    release_req();
    expect_item("R8 flag clears on release", int'(tot_expired), 0);
    run_tx(1000, n);
    expect_item("R8 restart gives full duration", n, 3 * TPS);
    release_req();

    // R7 clamping
    cfg_tot_code = 7'd0;
    run_tx(1000, n);
    expect_item("R7 code 0 acts as 1", n, TPS);
    release_req();
    cfg_tot_code = 7'd120;
    run_tx(1000, n);
    expect_item("R7 code 120 acts as 99", n, 99 * TPS);
    release_req();

    // R12 change during transmission ignored until idle
    cfg_tot_code = 7'd4;
    n = 0;
    tx_req = 1'b1;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (i == 4) cfg_tot_code = 7'd1;
      if (tx_en) n++;
      else break;
    end
    expect_item("R12 mid-run change ignored", n, 4 * TPS);
    release_req();
    run_tx(1000, n);
    expect_item("R12 new code used after idle", n, TPS);
    release_req();

    // R9 no limit when disabled
    cfg_tot_en = 1'b0;
    tx_req = 1'b1;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (tx_en) n++;
    end
    expect_item("R9 unlimited transmission", n, 100);
    release_req();

    // R3 lockout
    chan_busy = 1'b1;
    tx_req = 1'b1;
    n = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (tx_en) n++;
    end
    expect_item("R3 busy blocks request", n, 0);
    chan_busy = 1'b0;
    n = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (tx_en) n++;
    end
    expect_item("R3 held request stays blocked", n, 0);
    release_req();
    tx_req = 1'b1;
    @(negedge clk);
    expect_item("R3 fresh request granted", int'(tx_en), 1);
    release_req();

    // R5 busy during transmission
    tx_req = 1'b1;
    @(negedge clk);
    chan_busy = 1'b1;
    n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (tx_en) n++;
    end
    expect_item("R5 busy mid-run no cut", n, 10);
    release_req();

    // R4 lockout disabled
    cfg_lockout_en = 1'b0;
    tx_req = 1'b1;
    @(negedge clk);
    expect_item("R4 busy ignored without lockout", int'(tx_en), 1);
    release_req();
    chan_busy = 1'b0;

    // R10 power save
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (rx_pwr_en) n++;
    end
    expect_item("R10 power save off keeps receiver on", n, 20);
    cfg_ps_en = 1'b1;
    for (int i = 0; i < 50 && rx_pwr_en; i++) @(negedge clk);
    n = 0;
    for (int i = 0; i < 50 && !rx_pwr_en; i++) begin
      n++;
      @(negedge clk);
    end
    expect_item("R10 sleep run length", n, 2);
    n = 0;
    for (int i = 0; i < 50 && rx_pwr_en; i++) begin
      n++;
      @(negedge clk);
    end
    expect_item("R10 awake run length", n, 3);

    // R11 suspension by busy and by request
    for (int i = 0; i < 50 && rx_pwr_en; i++) @(negedge clk);
    chan_busy = 1'b1;
    @(negedge clk);
    expect_item("R11 busy wakes receiver", int'(rx_pwr_en), 1);
    n = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (rx_pwr_en) n++;
    end
    expect_item("R11 receiver kept on while busy", n, 8);
    chan_busy = 1'b0;
    for (int i = 0; i < 50 && rx_pwr_en; i++) @(negedge clk);
    tx_req = 1'b1;
    @(negedge clk);
    expect_item("R11 request wakes receiver", int'(rx_pwr_en), 1);
    release_req();

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule